// File: doc/BRIEF.md
# Resource Slot and Hold Tracker

This block keeps the issue-side bookkeeping for a single execution resource. It counts the free slots in the resource's reservation station and holds a one-bit hold flag that marks the resource as taken. From these it reports, every cycle, whether an instruction that needs the resource may be dispatched. It also keeps the largest slot occupancy seen since reset.

A single signed parameter, `BUF_DEPTH`, picks one of four behaviours. A depth of -1 gives a resource with no slot limit. A depth of 0 gives an in-order dispatch hazard: the resource is held from dispatch until its execution cycles are spent, and while it is held the block reports a held code. A depth of 1 gives a buffered unit that forces in-order execution. A larger depth gives an ordinary buffered reservation station.

The dispatch logic pulses `slot_take_i` when it dispatches into the station and `slot_give_i` when an entry leaves it. It drives `hold_set_i` and `hold_clr_i` around the hold window and reads `avail_o` before each dispatch.

Top module: `rsv_tracker`

## Requirements
- R1: The mode outputs are constants of `BUF_DEPTH`. `mode_buffered_o` is 1 when the depth is greater than 0. `mode_inorder_o` is 1 when the depth equals 1. `mode_hazard_o` is 1 when the depth equals 0.
- R2: `avail_o` uses three codes: 0 means available, 1 means slots exhausted and 2 means held. Code 2 appears only when the depth is 0 and the hold flag is set.
- R3: When code 2 does not apply, `avail_o` is 0 if the resource is not buffered or has at least one free slot. It is 1 if the resource is buffered and has no free slot.
- R4: A take lowers the free count by one on the next edge when the count is nonzero. A take at a free count of zero leaves the count at zero.
- R5: A give raises the free count by one only when the resource is buffered and the count is below `BUF_DEPTH`. Otherwise the give is ignored, so the free count never exceeds the depth.
- R6: `peak_o` holds the largest used count seen at any take. The used count is `BUF_DEPTH` minus the free count after that take. `peak_o` shows the new value one cycle after the take, never decreases outside reset, and stays 0 for a resource that is not buffered.
- R7: A take and a give in the same cycle act as the take followed by the give. The peak is computed from the state between the two.
- R8: `hold_set_i` and `hold_clr_i` update the hold flag, seen on `hold_o`, on the next edge. Set wins when both are high.
- R9: `hold_err_o` is high for the one cycle after an edge at which `hold_set_i` was high while `hold_o` was already 1.
- R10: Synchronous reset (`rst` high) sets the free count to `BUF_DEPTH` for a buffered resource and to 0 otherwise. It also clears the peak, the hold flag and the error output.
- R11: For any depth other than 0, the hold flag has no effect on `avail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_take_i | input | 1 | Reserve one station slot |
| slot_give_i | input | 1 | Release one station slot |
| hold_set_i | input | 1 | Set the hold flag |
| hold_clr_i | input | 1 | Clear the hold flag |
| avail_o | output | 2 | Availability code (0 available, 1 slots exhausted, 2 held) |
| peak_o | output | PW | Peak slot occupancy since reset |
| hold_o | output | 1 | Current hold flag |
| hold_err_o | output | 1 | Set requested while already held |
| mode_buffered_o | output | 1 | Depth greater than 0 |
| mode_inorder_o | output | 1 | Depth equal to 1 |
| mode_hazard_o | output | 1 | Depth equal to 0 |

## Verification
The assertions are checked on every cycle. They cover the bound of the free count at the depth and the exhausted count staying at zero under further takes. They also cover single-step decrements, a peak that never falls, the next-edge update of the hold flag, the error pulse, and the rule that the held and exhausted codes appear only in their own modes.

Some behaviours can only be shown by the bench's scenarios, because they depend on a sequence of operations. These are:
- the exact peak values;
- a give that is ignored at a full count, shown by counting the takes needed to exhaust the station again;
- the take-then-give order within one cycle;
- set priority over clear;
- the state restored by reset in the middle of a run;
- how each of the four depth modes differs from the others.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      AVL_OK   = 2'd0,
      AVL_FULL = 2'd1,
      AVL_HELD = 2'd2
   } avail_e;

   function automatic int pos_depth(input int depth);
      return (depth > 0) ? depth : 1;
   endfunction

   function automatic int cnt_width(input int depth);
      return $clog2(pos_depth(depth) + 1);
   endfunction

endpackage

// File: rtl/rsv_mode_decode.sv
module rsv_mode_decode #(
   parameter int BUF_DEPTH = 4
) (
   output logic buffered_o,
   output logic inorder_o,
   output logic hazard_o
);
   localparam bit IS_BUF = (BUF_DEPTH > 0);
   localparam bit IS_ONE = (BUF_DEPTH == 1);
   localparam bit IS_HAZ = (BUF_DEPTH == 0);

   always_comb begin
      buffered_o = IS_BUF;
      inorder_o  = IS_ONE;
      hazard_o   = IS_HAZ;
   end
endmodule

// File: rtl/rsv_slot_counter.sv
module rsv_slot_counter
   import rsv_pkg::*;
#(
   parameter int BUF_DEPTH = 4,
   localparam int PW = cnt_width(BUF_DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take_i,
   input  logic          give_i,
   output logic          empty_o,
   output logic [PW-1:0] peak_o
);
   localparam logic [PW-1:0] FULLV = PW'(pos_depth(BUF_DEPTH));

   generate
      if (BUF_DEPTH > 0) begin : g_buffered
         logic [PW-1:0] free_q, after_take, after_give, used_take, peak_q, peak_d;

         always_comb begin
            after_take = (take_i && free_q != '0) ? free_q - 1'b1 : free_q;
            used_take  = FULLV - after_take;
            after_give = (give_i && after_take != FULLV) ? after_take + 1'b1 : after_take;
            peak_d     = (take_i && used_take > peak_q) ? used_take : peak_q;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               free_q <= FULLV;
               peak_q <= '0;
            end else begin
               free_q <= after_give;
               peak_q <= peak_d;
            end
         end

         assign empty_o = (free_q == '0);
         assign peak_o  = peak_q;

         p_free_cap_r5: assert property (@(posedge clk) disable iff (rst)
            free_q <= FULLV);
         p_full_stick_r4: assert property (@(posedge clk) disable iff (rst)
            (take_i && !give_i && free_q == '0) |=> (free_q == '0));
         p_take_step_r4: assert property (@(posedge clk) disable iff (rst)
            (take_i && !give_i && free_q != '0) |=> (free_q == PW'($past(free_q) - 1'b1)));
         p_peak_mono_r6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (peak_q >= $past(peak_q)));
      end else begin : g_unbuffered
         assign empty_o = 1'b0;
         assign peak_o  = '0;
      end
   endgenerate
endmodule

// File: rtl/rsv_hold_flag.sv
module rsv_hold_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic hold_o,
   output logic err_o
);
   logic hold_q, err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (set_i)      hold_q <= 1'b1;
         else if (clr_i) hold_q <= 1'b0;
         err_q <= set_i & hold_q;
      end
   end

   assign hold_o = hold_q;
   assign err_o  = err_q;

   p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set_i |=> hold_q);
   p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i) |=> !hold_q);
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      (set_i && hold_q) |=> err_q);
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
   import rsv_pkg::*;
#(
   parameter int BUF_DEPTH = 4,
   parameter int MAX_DEPTH = 4096,
   localparam int PW = cnt_width(BUF_DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          slot_take_i,
   input  logic          slot_give_i,
   input  logic          hold_set_i,
   input  logic          hold_clr_i,
   output logic [1:0]    avail_o,
   output logic [PW-1:0] peak_o,
   output logic          hold_o,
   output logic          hold_err_o,
   output logic          mode_buffered_o,
   output logic          mode_inorder_o,
   output logic          mode_hazard_o
);
   generate
      if (BUF_DEPTH < -1 || BUF_DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("rsv_tracker: BUF_DEPTH out of range");
      end
   endgenerate

   logic   is_buf, is_one, is_haz, empty, held;
   avail_e code;

   rsv_mode_decode #(.BUF_DEPTH(BUF_DEPTH)) u_mode (
      .buffered_o (is_buf),
      .inorder_o  (is_one),
      .hazard_o   (is_haz)
   );

   rsv_slot_counter #(.BUF_DEPTH(BUF_DEPTH)) u_slots (
      .clk     (clk),
      .rst     (rst),
      .take_i  (slot_take_i),
      .give_i  (slot_give_i),
      .empty_o (empty),
      .peak_o  (peak_o)
   );

   rsv_hold_flag u_hold (
      .clk    (clk),
      .rst    (rst),
      .set_i  (hold_set_i),
      .clr_i  (hold_clr_i),
      .hold_o (held),
      .err_o  (hold_err_o)
   );

   always_comb begin
      if (is_haz && held)      code = AVL_HELD;
      else if (is_buf && empty) code = AVL_FULL;
      else                      code = AVL_OK;
   end

   assign avail_o         = code;
   assign hold_o          = held;
   assign mode_buffered_o = is_buf;
   assign mode_inorder_o  = is_one;
   assign mode_hazard_o   = is_haz;

   p_held_only_hazard_r2: assert property (@(posedge clk) disable iff (rst)
      (avail_o == AVL_HELD) |-> mode_hazard_o);
   p_full_only_buffered_r3: assert property (@(posedge clk) disable iff (rst)
      (avail_o == AVL_FULL) |-> mode_buffered_o);
   p_hazard_held_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_hazard_o && hold_o) |-> (avail_o == AVL_HELD));
endmodule

// File: tb/rsv_tracker_tb.sv
module rsv_tracker_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic take = 1'b0, give = 1'b0, hset = 1'b0, hclr = 1'b0;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   logic [1:0] av3, avh, avu, av1;
   logic [1:0] pk3;
   logic [0:0] pkh, pku, pk1;
   logic h3, hh, hu, h1, e3, eh, eu, e1;
   logic b3, o3, z3, bh, oh, zh, bu, ou, zu, b1, o1, z1;

   rsv_tracker #(.BUF_DEPTH(3)) u_dut (
      .clk(clk), .rst(rst), .slot_take_i(take), .slot_give_i(give),
      .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av3), .peak_o(pk3),
      .hold_o(h3), .hold_err_o(e3), .mode_buffered_o(b3), .mode_inorder_o(o3),
      .mode_hazard_o(z3));
   rsv_tracker #(.BUF_DEPTH(0)) u_dut_haz (
      .clk(clk), .rst(rst), .slot_take_i(take), .slot_give_i(give),
      .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(avh), .peak_o(pkh),
      .hold_o(hh), .hold_err_o(eh), .mode_buffered_o(bh), .mode_inorder_o(oh),
      .mode_hazard_o(zh));
   rsv_tracker #(.BUF_DEPTH(-1)) u_dut_unl (
      .clk(clk), .rst(rst), .slot_take_i(take), .slot_give_i(give),
      .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(avu), .peak_o(pku),
      .hold_o(hu), .hold_err_o(eu), .mode_buffered_o(bu), .mode_inorder_o(ou),
      .mode_hazard_o(zu));
   rsv_tracker #(.BUF_DEPTH(1)) u_dut_one (
      .clk(clk), .rst(rst), .slot_take_i(take), .slot_give_i(give),
      .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av1), .peak_o(pk1),
      .hold_o(h1), .hold_err_o(e1), .mode_buffered_o(b1), .mode_inorder_o(o1),
      .mode_hazard_o(z1));

   // {take,give,set,clr}, avail, peak, hold, err  (depth 3)
   localparam int NV = 18;
   localparam logic [11:0] VEC [NV] = '{
      {4'b1000, 2'd0, 4'd1, 1'b0, 1'b0},
      {4'b1000, 2'd0, 4'd2, 1'b0, 1'b0},
      {4'b1000, 2'd1, 4'd3, 1'b0, 1'b0},
      {4'b1000, 2'd1, 4'd3, 1'b0, 1'b0},   // take at zero: R4
      {4'b0100, 2'd0, 4'd3, 1'b0, 1'b0},
      {4'b1100, 2'd0, 4'd3, 1'b0, 1'b0},   // take+give: R7
      {4'b0100, 2'd0, 4'd3, 1'b0, 1'b0},
      {4'b0100, 2'd0, 4'd3, 1'b0, 1'b0},
      {4'b0100, 2'd0, 4'd3, 1'b0, 1'b0},   // give at full count ignored: R5
      {4'b1000, 2'd0, 4'd3, 1'b0, 1'b0},
      {4'b1000, 2'd0, 4'd3, 1'b0, 1'b0},
      {4'b1000, 2'd1, 4'd3, 1'b0, 1'b0},   // exhausted after 3 takes: R5
      {4'b0010, 2'd1, 4'd3, 1'b1, 1'b0},   // hold ignored by avail: R11
      {4'b0010, 2'd1, 4'd3, 1'b1, 1'b1},
      {4'b0000, 2'd1, 4'd3, 1'b1, 1'b0},
      {4'b0011, 2'd1, 4'd3, 1'b1, 1'b1},
      {4'b0001, 2'd1, 4'd3, 1'b0, 1'b0},
      {4'b0100, 2'd0, 4'd3, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic t, input logic g, input logic s, input logic c);
      take = t; give = g; hset = s; hclr = c;
      step();
      take = 1'b0; give = 1'b0; hset = 1'b0; hclr = 1'b0;
   endtask

   task automatic reset_all();
      rst = 1'b1;
      step();
      step();
      rst = 1'b0;
   endtask

   function automatic string avail_tag(input int i);
      case (i)
         3:       return "R4";
         5:       return "R7";
         11:      return "R5";
         12:      return "R11";
         default: return "R3";
      endcase
   endfunction

   initial begin
      @(negedge clk);
      reset_all();
      // reset state and modes
      check("R10 avail", av3, 0);
      check("R10 peak", pk3, 0);
      check("R10 hold", h3, 0);
      check("R10 err", e3, 0);
      check("R1 depth3", {b3, o3, z3}, 3'b100);
      check("R1 depth0", {bh, oh, zh}, 3'b001);
      check("R1 depth-1", {bu, ou, zu}, 3'b000);
      check("R1 depth1", {b1, o1, z1}, 3'b110);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
         check(avail_tag(i), av3, VEC[i][7:6]);
         check("R6 peak", pk3, VEC[i][5:2]);
         check("R8 hold", h3, VEC[i][1]);
         check("R9 err", e3, VEC[i][0]);
      end

      // mid-run reset restores free count and clears peak
      reset_all();
      check("R10 peak after reset", pk3, 0);
      drive(1, 0, 0, 0);
      drive(1, 0, 0, 0);
      check("R10 free restored", av3, 0);
      drive(1, 0, 0, 0);
      check("R10 free restored", av3, 1);

      // dispatch hazard mode
      reset_all();
      check("R2 hazard idle", avh, 0);
      drive(0, 0, 1, 0);
      check("R2 hazard held", avh, 2);
      drive(1, 0, 0, 0);
      check("R2 hazard still held", avh, 2);
      check("R6 hazard peak", pkh, 0);
      drive(0, 0, 0, 1);
      check("R2 hazard released", avh, 0);

      // unlimited mode
      reset_all();
      for (int k = 0; k < 5; k++) drive(1, 0, 0, 0);
      check("R3 unlimited avail", avu, 0);
      check("R6 unlimited peak", pku, 0);
      drive(0, 0, 1, 0);
      check("R11 unlimited hold ignored", avu, 0);
      check("R8 unlimited hold", hu, 1);

      // in-order unit
      reset_all();
      drive(1, 0, 0, 0);
      check("R4 inorder full", av1, 1);
      check("R6 inorder peak", pk1, 1);
      drive(0, 1, 0, 0);
      check("R5 inorder give", av1, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule